// File: doc/BRIEF.md
# Direct Segment Address Translator

This block converts 48-bit virtual addresses into 41-bit physical addresses for a data-side memory pipeline. Alongside the conventional data-TLB lookup, it compares every address against one contiguous region. That region is described by three per-process registers: a lower bound, an exclusive upper bound and a displacement. An address inside the region is translated by subtracting the displacement, so it can never miss in the TLB or start a page walk.

Addresses outside the region take the paging path. A TLB hit supplies a frame number for a 4 KB, 2 MB or 1 GB page. A TLB miss sends the virtual page number to an external page-table walker, and that walker's reply, which may carry a fault, completes the translation.

The operating system programs the three registers and reads them back through a small select/write port, so it can save and restore them when it switches processes. If the upper bound is not above the lower bound, the region is off. Reset leaves it off. Only one translation is in flight at a time.

Top module: `dseg_xlate`

## Requirements
- R1: After reset all three region registers read zero and the region is off. Whenever the upper bound is less than or equal to the lower bound, every access takes the paging path (rsp_seg=0).
- R2: An address is in the region exactly when lower bound <= VA < upper bound. Both comparisons are unsigned and 48 bits wide. Equality with the upper bound is outside the region.
- R3: For an in-region access, rsp_valid rises in the cycle after the request is accepted, with rsp_seg=1, rsp_fault=0 and rsp_pa equal to the low 41 bits of (VA minus displacement), taken modulo 2^48.
- R4: For an in-region access, any TLB result that arrives is ignored: no walk request is issued, and the block is ready for a new request in the cycle after acceptance.
- R5: For an out-of-region access, a TLB hit (tlb_valid=1, tlb_hit=1) produces a response in the cycle after tlb_valid. rsp_seg is 0 and rsp_pa is built from the frame number and the VA. The size codes are 0 for 4 KB (VA bits 11..0 kept), 1 for 2 MB (VA bits 20..0 kept) and 2 for 1 GB (VA bits 29..0 kept). Code 3 is treated as 4 KB.
- R6: For an out-of-region access, a TLB miss raises walk_req_valid for exactly one cycle, in the cycle after tlb_valid, with walk_vpn equal to VA bits 47..12. No response is given yet.
- R7: A walker reply produces a response in the next cycle. When walk_fault=0, rsp_pa is built with the same size rules as R5. When walk_fault=1, rsp_fault=1 and rsp_pa=0.
- R8: Register select codes are 0 for the lower bound, 1 for the upper bound, 2 for the displacement, and 3, which reads zero and ignores writes. cfg_rdata shows the selected register one cycle after cfg_sel is applied. A write with cfg_wr=1 updates the register at the clock edge.
- R9: req_ready is high when idle. It is low from the cycle after a paging-path request is accepted until the cycle in which its response appears.
- R10: A register write made while a translation is outstanding does not change that translation's path. The first request accepted after the write uses the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select (R8 codes) |
| cfg_wdata | input | 48 | Register write data |
| cfg_rdata | output | 48 | Registered read data of the selected register |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Block can accept a request |
| req_va | input | 48 | Virtual address of the request |
| tlb_valid | input | 1 | TLB result present |
| tlb_hit | input | 1 | TLB result is a hit |
| tlb_ppn | input | 29 | Physical frame number from the TLB |
| tlb_size | input | 2 | Page size code from the TLB |
| walk_req_valid | output | 1 | One-cycle page walk request |
| walk_vpn | output | 36 | Virtual page number to walk |
| walk_rsp_valid | input | 1 | Walker reply present |
| walk_ppn | input | 29 | Physical frame number from the walker |
| walk_size | input | 2 | Page size code from the walker |
| walk_fault | input | 1 | Walker found no mapping |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_pa | output | 41 | Translated physical address |
| rsp_seg | output | 1 | Response came from the region path |
| rsp_fault | output | 1 | Translation faulted |

## Verification
The embedded properties are checked on every cycle. They cover the fixed timing: the one-cycle latency of region hits and the absence of a walk after them, the single-cycle walk strobe, ready going low after a paging acceptance, and register writes landing. They also cover the rule that a faulting response is never a region response and always carries a zero address.

The bench's scenarios are needed for the data-dependent behaviour. This includes the inclusive and exclusive range boundaries, a displacement that wraps below zero, the three page-size compositions and the reserved size code. It also includes the disabled region after reset and when the bounds are equal, and a write to the bounds made during a walk that must leave the pending translation on the paging path.

// File: rtl/dseg_pkg.sv
package dseg_pkg;
  localparam int VA_BITS    = 48;
  localparam int PA_BITS    = 41;
  localparam int PAGE_BITS  = 12;
  localparam int LEVEL_BITS = 9;

  typedef enum logic [1:0] {
    SEL_LOWER = 2'd0,
    SEL_UPPER = 2'd1,
    SEL_DISP  = 2'd2,
    SEL_NONE  = 2'd3
  } cfg_sel_e;

  typedef enum logic [1:0] {
    PG_4K  = 2'd0,
    PG_2M  = 2'd1,
    PG_1G  = 2'd2,
    PG_RSV = 2'd3
  } pg_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TLB  = 2'd1,
    ST_WALK = 2'd2
  } xl_state_e;
endpackage

// File: rtl/dseg_regs.sv
module dseg_regs
  import dseg_pkg::*;
#(
  parameter int VA_W = VA_BITS
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_wr,
  input  logic [1:0]      cfg_sel,
  input  logic [VA_W-1:0] cfg_wdata,
  output logic [VA_W-1:0] cfg_rdata,
  output logic [VA_W-1:0] lower_o,
  output logic [VA_W-1:0] upper_o,
  output logic [VA_W-1:0] disp_o
);
  cfg_sel_e        sel;
  logic [VA_W-1:0] rd_mux;

  assign sel = cfg_sel_e'(cfg_sel);

  always_comb begin
    case (sel)
      SEL_LOWER: rd_mux = lower_o;
      SEL_UPPER: rd_mux = upper_o;
      SEL_DISP:  rd_mux = disp_o;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lower_o   <= '0;
      upper_o   <= '0;
      disp_o    <= '0;
      cfg_rdata <= '0;
    end else begin
      cfg_rdata <= rd_mux;
      if (cfg_wr) begin
        case (sel)
          SEL_LOWER: lower_o <= cfg_wdata;
          SEL_UPPER: upper_o <= cfg_wdata;
          SEL_DISP:  disp_o  <= cfg_wdata;
          default:   ;
        endcase
      end
    end
  end

  // R8
  lower_write_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && sel == SEL_LOWER) |=> (lower_o == $past(cfg_wdata)));

  // R8
  upper_write_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && sel == SEL_UPPER) |=> (upper_o == $past(cfg_wdata)));
endmodule

// File: rtl/dseg_match.sv
module dseg_match
  import dseg_pkg::*;
#(
  parameter int VA_W = VA_BITS,
  parameter int PA_W = PA_BITS
) (
  input  logic [VA_W-1:0] va,
  input  logic [VA_W-1:0] lower,
  input  logic [VA_W-1:0] upper,
  input  logic [VA_W-1:0] disp,
  output logic            in_seg,
  output logic [PA_W-1:0] seg_pa
);
  localparam int HI_W = VA_W - PA_W;

  logic [HI_W-1:0] seg_hi_unused;
  logic            ge_lower;
  logic            lt_upper;

  assign ge_lower = (va >= lower);
  assign lt_upper = (va < upper);
  assign in_seg   = ge_lower && lt_upper;
  assign {seg_hi_unused, seg_pa} = va - disp;
endmodule

// File: rtl/dseg_compose.sv
module dseg_compose
  import dseg_pkg::*;
#(
  parameter int PA_W = PA_BITS,
  parameter int PG_W = PAGE_BITS,
  parameter int LV_W = LEVEL_BITS
) (
  input  logic [PA_W-1:0]      va_low,
  input  logic [PA_W-PG_W-1:0] ppn,
  input  logic [1:0]           size,
  output logic [PA_W-1:0]      pa
);
  localparam int SH_SMALL = PG_W;
  localparam int SH_MID   = PG_W + LV_W;
  localparam int SH_LARGE = PG_W + 2 * LV_W;

  logic [PA_W-1:0] keep_mask;
  logic [PA_W-1:0] frame;

  assign frame = {ppn, {PG_W{1'b0}}};

  always_comb begin
    case (pg_size_e'(size))
      PG_2M:   keep_mask = ~({PA_W{1'b1}} << SH_MID);
      PG_1G:   keep_mask = ~({PA_W{1'b1}} << SH_LARGE);
      default: keep_mask = ~({PA_W{1'b1}} << SH_SMALL);
    endcase
  end

  assign pa = (frame & ~keep_mask) | (va_low & keep_mask);
endmodule

// File: rtl/dseg_ctrl.sv
module dseg_ctrl
  import dseg_pkg::*;
#(
  parameter int VA_W = VA_BITS,
  parameter int PA_W = PA_BITS,
  parameter int PG_W = PAGE_BITS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [VA_W-1:0]      req_va,
  input  logic                 in_seg,
  input  logic [PA_W-1:0]      seg_pa,
  input  logic                 tlb_valid,
  input  logic                 tlb_hit,
  input  logic [PA_W-PG_W-1:0] tlb_ppn,
  input  logic [1:0]           tlb_size,
  output logic                 walk_req_valid,
  output logic [VA_W-PG_W-1:0] walk_vpn,
  input  logic                 walk_rsp_valid,
  input  logic [PA_W-PG_W-1:0] walk_ppn,
  input  logic [1:0]           walk_size,
  input  logic                 walk_fault,
  output logic                 rsp_valid,
  output logic [PA_W-1:0]      rsp_pa,
  output logic                 rsp_seg,
  output logic                 rsp_fault
);
  localparam int PPN_W = PA_W - PG_W;

  xl_state_e        state;
  logic [VA_W-1:0]  va_q;
  logic [PPN_W-1:0] pick_ppn;
  logic [1:0]       pick_size;
  logic [PA_W-1:0]  page_pa;

  assign req_ready = (state == ST_IDLE);
  assign pick_ppn  = (state == ST_WALK) ? walk_ppn  : tlb_ppn;
  assign pick_size = (state == ST_WALK) ? walk_size : tlb_size;

  dseg_compose #(.PA_W(PA_W), .PG_W(PG_W)) u_compose (
    .va_low (va_q[PA_W-1:0]),
    .ppn    (pick_ppn),
    .size   (pick_size),
    .pa     (page_pa)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state          <= ST_IDLE;
      va_q           <= '0;
      walk_req_valid <= 1'b0;
      walk_vpn       <= '0;
      rsp_valid      <= 1'b0;
      rsp_pa         <= '0;
      rsp_seg        <= 1'b0;
      rsp_fault      <= 1'b0;
    end else begin
      rsp_valid      <= 1'b0;
      walk_req_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            va_q <= req_va;
            if (in_seg) begin
              rsp_valid <= 1'b1;
              rsp_pa    <= seg_pa;
              rsp_seg   <= 1'b1;
              rsp_fault <= 1'b0;
            end else begin
              state <= ST_TLB;
            end
          end
        end
        ST_TLB: begin
          if (tlb_valid) begin
            if (tlb_hit) begin
              rsp_valid <= 1'b1;
              rsp_pa    <= page_pa;
              rsp_seg   <= 1'b0;
              rsp_fault <= 1'b0;
              state     <= ST_IDLE;
            end else begin
              walk_req_valid <= 1'b1;
              walk_vpn       <= va_q[VA_W-1:PG_W];
              state          <= ST_WALK;
            end
          end
        end
        ST_WALK: begin
          if (walk_rsp_valid) begin
            rsp_valid <= 1'b1;
            rsp_pa    <= walk_fault ? '0 : page_pa;
            rsp_seg   <= 1'b0;
            rsp_fault <= walk_fault;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3
  seg_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_seg) |-> $past(req_valid && req_ready));

  // R4
  seg_no_walk_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && in_seg) |=> (!walk_req_valid && req_ready));

  // R6
  walk_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    walk_req_valid |=> !walk_req_valid);

  // R7
  fault_paging_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault) |-> (!rsp_seg && rsp_pa == '0));

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !in_seg) |=> !req_ready);
endmodule

// File: rtl/dseg_xlate.sv
module dseg_xlate
  import dseg_pkg::*;
#(
  parameter int VA_W = VA_BITS,
  parameter int PA_W = PA_BITS,
  parameter int PG_W = PAGE_BITS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_wr,
  input  logic [1:0]           cfg_sel,
  input  logic [VA_W-1:0]      cfg_wdata,
  output logic [VA_W-1:0]      cfg_rdata,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [VA_W-1:0]      req_va,
  input  logic                 tlb_valid,
  input  logic                 tlb_hit,
  input  logic [PA_W-PG_W-1:0] tlb_ppn,
  input  logic [1:0]           tlb_size,
  output logic                 walk_req_valid,
  output logic [VA_W-PG_W-1:0] walk_vpn,
  input  logic                 walk_rsp_valid,
  input  logic [PA_W-PG_W-1:0] walk_ppn,
  input  logic [1:0]           walk_size,
  input  logic                 walk_fault,
  output logic                 rsp_valid,
  output logic [PA_W-1:0]      rsp_pa,
  output logic                 rsp_seg,
  output logic                 rsp_fault
);
  logic [VA_W-1:0] lower_q;
  logic [VA_W-1:0] upper_q;
  logic [VA_W-1:0] disp_q;
  logic            hit_seg;
  logic [PA_W-1:0] hit_pa;

  dseg_regs #(.VA_W(VA_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .cfg_wr    (cfg_wr),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .lower_o   (lower_q),
    .upper_o   (upper_q),
    .disp_o    (disp_q)
  );

  dseg_match #(.VA_W(VA_W), .PA_W(PA_W)) u_match (
    .va     (req_va),
    .lower  (lower_q),
    .upper  (upper_q),
    .disp   (disp_q),
    .in_seg (hit_seg),
    .seg_pa (hit_pa)
  );

  dseg_ctrl #(.VA_W(VA_W), .PA_W(PA_W), .PG_W(PG_W)) u_ctrl (
    .clk            (clk),
    .rst            (rst),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_va         (req_va),
    .in_seg         (hit_seg),
    .seg_pa         (hit_pa),
    .tlb_valid      (tlb_valid),
    .tlb_hit        (tlb_hit),
    .tlb_ppn        (tlb_ppn),
    .tlb_size       (tlb_size),
    .walk_req_valid (walk_req_valid),
    .walk_vpn       (walk_vpn),
    .walk_rsp_valid (walk_rsp_valid),
    .walk_ppn       (walk_ppn),
    .walk_size      (walk_size),
    .walk_fault     (walk_fault),
    .rsp_valid      (rsp_valid),
    .rsp_pa         (rsp_pa),
    .rsp_seg        (rsp_seg),
    .rsp_fault      (rsp_fault)
  );
endmodule

// File: tb/dseg_xlate_test.sv
module dseg_xlate_test;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [47:0] cfg_wdata = '0;
  logic [47:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [47:0] req_va = '0;
  logic        tlb_valid = 1'b0, tlb_hit = 1'b0;
  logic [28:0] tlb_ppn = '0;
  logic [1:0]  tlb_size = '0;
  logic        walk_req_valid;
  logic [35:0] walk_vpn;
  logic        walk_rsp_valid = 1'b0, walk_fault = 1'b0;
  logic [28:0] walk_ppn = '0;
  logic [1:0]  walk_size = '0;
  logic        rsp_valid, rsp_seg, rsp_fault;
  logic [40:0] rsp_pa;

  int checks = 0;
  int fails  = 0;

  dseg_xlate uut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
    .tlb_valid(tlb_valid), .tlb_hit(tlb_hit), .tlb_ppn(tlb_ppn),
    .tlb_size(tlb_size), .walk_req_valid(walk_req_valid),
    .walk_vpn(walk_vpn), .walk_rsp_valid(walk_rsp_valid),
    .walk_ppn(walk_ppn), .walk_size(walk_size), .walk_fault(walk_fault),
    .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_seg(rsp_seg),
    .rsp_fault(rsp_fault)
  );

  always #(CLK_NS / 2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [40:0] build_pa(input logic [47:0] va,
                                           input logic [28:0] ppn,
                                           input logic [1:0] sz);
    logic [40:0] frame;
    frame = {ppn, 12'h000};
    case (sz)
      2'd1:    return {frame[40:21], va[20:0]};
      2'd2:    return {frame[40:30], va[29:0]};
      default: return {frame[40:12], va[11:0]};
    endcase
  endfunction

  // Behavioural reference model, updated on every rising edge
  int          m_phase;
  logic [47:0] m_va, m_lo, m_hi, m_disp;
  logic        e_rsp, e_seg, e_fault, e_walk, e_ready;
  logic [40:0] e_pa;
  logic [35:0] e_vpn;
  logic [47:0] e_rdata;
  string       m_tag = "R3";

  always @(posedge clk) begin
    logic [47:0] diff;
    if (rst) begin
      m_phase = 0; m_lo = '0; m_hi = '0; m_disp = '0; m_va = '0;
      e_rsp = 0; e_seg = 0; e_fault = 0; e_walk = 0; e_ready = 1;
      e_pa = '0; e_vpn = '0; e_rdata = '0;
    end else begin
      e_rsp = 0;
      e_walk = 0;
      case (cfg_sel)
        2'd0: e_rdata = m_lo;
        2'd1: e_rdata = m_hi;
        2'd2: e_rdata = m_disp;
        default: e_rdata = '0;
      endcase
      if (m_phase == 0) begin
        if (req_valid) begin
          m_va = req_va;
          if (req_va >= m_lo && req_va < m_hi) begin
            diff = req_va - m_disp;
            e_rsp = 1; e_seg = 1; e_fault = 0; e_pa = diff[40:0];
            m_tag = "R3";
          end else m_phase = 1;
        end
      end else if (m_phase == 1) begin
        if (tlb_valid) begin
          if (tlb_hit) begin
            e_rsp = 1; e_seg = 0; e_fault = 0;
            e_pa = build_pa(m_va, tlb_ppn, tlb_size);
            m_tag = "R5"; m_phase = 0;
          end else begin
            e_walk = 1; e_vpn = m_va[47:12]; m_phase = 2;
          end
        end
      end else begin
        if (walk_rsp_valid) begin
          e_rsp = 1; e_seg = 0; e_fault = walk_fault;
          e_pa = walk_fault ? '0 : build_pa(m_va, walk_ppn, walk_size);
          m_tag = "R7"; m_phase = 0;
        end
      end
      e_ready = (m_phase == 0);
      if (cfg_wr) begin
        case (cfg_sel)
          2'd0: m_lo = cfg_wdata;
          2'd1: m_hi = cfg_wdata;
          2'd2: m_disp = cfg_wdata;
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk(req_ready === e_ready, "R9", "model req_ready", 64'(req_ready), 64'(e_ready));
      chk(cfg_rdata === e_rdata, "R8", "model cfg_rdata", 64'(cfg_rdata), 64'(e_rdata));
      chk(rsp_valid === e_rsp, m_tag, "model rsp_valid", 64'(rsp_valid), 64'(e_rsp));
      if (e_rsp) begin
        chk(rsp_pa === e_pa, m_tag, "model rsp_pa", 64'(rsp_pa), 64'(e_pa));
        chk(rsp_seg === e_seg, m_tag, "model rsp_seg", 64'(rsp_seg), 64'(e_seg));
        chk(rsp_fault === e_fault, m_tag, "model rsp_fault", 64'(rsp_fault), 64'(e_fault));
      end
      chk(walk_req_valid === e_walk, "R6", "model walk_req_valid",
          64'(walk_req_valid), 64'(e_walk));
      if (e_walk)
        chk(walk_vpn === e_vpn, "R6", "model walk_vpn", 64'(walk_vpn), 64'(e_vpn));
    end
  end

  task automatic cfg_write(input logic [1:0] sel, input logic [47:0] data);
    @(negedge clk);
    cfg_wr = 1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic cfg_read(input logic [1:0] sel, input logic [47:0] exp, input string tag);
    @(negedge clk);
    cfg_sel = sel;
    @(negedge clk);
    chk(cfg_rdata === exp, tag, "readback", 64'(cfg_rdata), 64'(exp));
  endtask

  task automatic lookup(input logic [47:0] va);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_va = va;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic tlb_reply(input logic hit, input logic [28:0] ppn, input logic [1:0] sz);
    tlb_valid = 1; tlb_hit = hit; tlb_ppn = ppn; tlb_size = sz;
    @(negedge clk);
    tlb_valid = 0;
  endtask

  task automatic walk_reply(input logic [28:0] ppn, input logic [1:0] sz, input logic flt);
    walk_rsp_valid = 1; walk_ppn = ppn; walk_size = sz; walk_fault = flt;
    @(negedge clk);
    walk_rsp_valid = 0; walk_fault = 0;
  endtask

  task automatic expect_rsp(input logic seg, input logic [40:0] pa,
                            input logic flt, input string tag);
    chk(rsp_valid === 1'b1, tag, "rsp_valid", 64'(rsp_valid), 64'd1);
    chk(rsp_seg === seg, tag, "rsp_seg", 64'(rsp_seg), 64'(seg));
    chk(rsp_pa === pa, tag, "rsp_pa", 64'(rsp_pa), 64'(pa));
    chk(rsp_fault === flt, tag, "rsp_fault", 64'(rsp_fault), 64'(flt));
  endtask

  localparam logic [47:0] LO   = 48'h0000_4000_0000;
  localparam logic [47:0] HI   = 48'h0000_8000_0000;
  localparam logic [47:0] PST  = 48'h0000_1_0000_0000;
  localparam logic [47:0] DISP = LO - PST;

  initial begin
    logic [47:0] t;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(req_ready === 1'b1, "R9", "ready after reset", 64'(req_ready), 64'd1);
    chk(rsp_valid === 1'b0, "R1", "no rsp after reset", 64'(rsp_valid), 64'd0);
    cfg_read(2'd0, 48'h0, "R1");
    cfg_read(2'd1, 48'h0, "R1");

    // Region off after reset: paging path
    lookup(LO);
    chk(rsp_valid === 1'b0, "R1", "disabled region no fast rsp", 64'(rsp_valid), 64'd0);
    tlb_reply(1, 29'h0_1234_5, 2'd0);
    expect_rsp(0, build_pa(LO, 29'h0_1234_5, 2'd0), 0, "R1");

    cfg_write(2'd0, LO);
    cfg_write(2'd1, HI);
    cfg_write(2'd2, DISP);
    cfg_write(2'd3, 48'hFFFF_FFFF_FFFF);
    cfg_read(2'd0, LO, "R8");
    cfg_read(2'd1, HI, "R8");
    cfg_read(2'd2, DISP, "R8");
    cfg_read(2'd3, 48'h0, "R8");

    // Lower bound is inside; a TLB miss afterwards must be ignored
    lookup(LO);
    expect_rsp(1, PST[40:0], 0, "R2");
    chk(req_ready === 1'b1, "R4", "ready after region hit", 64'(req_ready), 64'd1);
    tlb_reply(0, 29'h0, 2'd0);
    chk(walk_req_valid === 1'b0, "R4", "no walk after region hit", 64'(walk_req_valid), 64'd0);

    t = HI - 1 - DISP;
    lookup(HI - 1);
    expect_rsp(1, t[40:0], 0, "R3");

    // Upper bound is outside
    lookup(HI);
    chk(rsp_valid === 1'b0, "R2", "upper bound not in region", 64'(rsp_valid), 64'd0);
    tlb_reply(1, 29'h1ABC_DE00, 2'd1);
    expect_rsp(0, build_pa(HI, 29'h1ABC_DE00, 2'd1), 0, "R5");

    lookup(LO - 1);
    chk(rsp_valid === 1'b0, "R2", "below lower bound", 64'(rsp_valid), 64'd0);
    tlb_reply(1, 29'h0AAA_AAAA, 2'd2);
    expect_rsp(0, build_pa(LO - 1, 29'h0AAA_AAAA, 2'd2), 0, "R5");

    lookup(48'h0000_0000_5FFF);
    tlb_reply(1, 29'h1555_5555, 2'd3);
    expect_rsp(0, build_pa(48'h0000_0000_5FFF, 29'h1555_5555, 2'd0), 0, "R5");

    // Miss then walker reply
    lookup(48'h7FFF_1234_5678);
    tlb_reply(0, 29'h0, 2'd0);
    chk(walk_req_valid === 1'b1, "R6", "walk request", 64'(walk_req_valid), 64'd1);
    chk(walk_vpn === 36'h7FFF_1234_5, "R6", "walk vpn", 64'(walk_vpn), 64'h7FFF_1234_5);
    chk(rsp_valid === 1'b0, "R6", "no rsp on miss", 64'(rsp_valid), 64'd0);
    @(negedge clk);
    chk(walk_req_valid === 1'b0, "R6", "walk pulse single", 64'(walk_req_valid), 64'd0);
    walk_reply(29'h0012_3456, 2'd1, 0);
    expect_rsp(0, build_pa(48'h7FFF_1234_5678, 29'h0012_3456, 2'd1), 0, "R7");

    lookup(48'h0100_0000_0000);
    tlb_reply(0, 29'h0, 2'd0);
    walk_reply(29'h1FFF_FFFF, 2'd0, 1);
    expect_rsp(0, 41'h0, 1, "R7");

    // Write during an outstanding translation
    lookup(48'h0000_9000_0000);
    cfg_write(2'd1, 48'h0000_A000_0000);
    chk(req_ready === 1'b0, "R9", "busy during translation", 64'(req_ready), 64'd0);
    tlb_reply(0, 29'h0, 2'd0);
    chk(walk_req_valid === 1'b1, "R10", "pending stays paging", 64'(walk_req_valid), 64'd1);
    walk_reply(29'h0000_0777, 2'd0, 0);
    expect_rsp(0, build_pa(48'h0000_9000_0000, 29'h0000_0777, 2'd0), 0, "R10");
    t = 48'h0000_9000_0000 - DISP;
    lookup(48'h0000_9000_0000);
    expect_rsp(1, t[40:0], 0, "R10");

    // Equal bounds disable the region
    cfg_write(2'd1, LO);
    lookup(LO);
    chk(rsp_valid === 1'b0, "R1", "equal bounds disabled", 64'(rsp_valid), 64'd0);
    tlb_reply(1, 29'h0000_0042, 2'd0);
    expect_rsp(0, build_pa(LO, 29'h0000_0042, 2'd0), 0, "R1");

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_NS * 100000);
    fails++;
    $display("FAIL R9 watchdog act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule